// File: doc/BRIEF.md
# User-Level Alert Delivery Unit

This unit sits between a cache's event detector and a processor's fetch and trap logic. Software first registers a handler address. From then on, the unit turns each incoming cache alert into a control transfer. The alert names an affected line and an event kind (remote write, local write, or capacity/conflict eviction).

In user mode, an accepted alert becomes a hardware-forced subroutine call. A one-cycle redirect pulse carries the handler address to fetch, and the interrupted PC is kept in a saved-PC register. In kernel mode, the same alert raises a one-cycle interrupt request instead, and the saved PC is left alone. Every accepted alert records its line and kind in a description register. Every accepted alert also masks further delivery until software re-arms the unit. Alerts that arrive while masked set a sticky lost flag. Clearing the handler disables delivery and emits a one-cycle request to the cache to release every marked line.

All outputs are registered. An alert presented with a rising clock edge shows its effects on the outputs straight after that edge.

Top module: `alert_dispatch_unit`

## Requirements
- R1: A set-handler strobe loads `hdl_addr_i` into the handler register and sets `enabled_o` after the edge. Later user-mode deliveries present that address on `redirect_addr_o`.
- R2: A clear-handler strobe clears `enabled_o` and `masked_o` after the edge. It also raises `release_all_o` for exactly one cycle. When both strobes come together, clear wins.
- R3: An accepted user-mode alert (`kernel_i`=0) raises `redirect_o` for one cycle after the edge. In that same cycle, `saved_pc_o` holds the `cur_pc_i` presented with the alert.
- R4: An accepted kernel-mode alert (`kernel_i`=1) raises `irq_o` for one cycle and gives no redirect. `saved_pc_o` stays unchanged.
- R5: Every accepted alert latches `alert_line_i` into `desc_line_o` and `alert_kind_i` into `desc_kind_o`. The kind codes are 0 for a remote write, 1 for a local write and 2 for an eviction.
- R6: After an accepted alert, `masked_o` is 1. Further alerts are not delivered until a re-arm strobe clears the mask.
- R7: An alert that arrives while enabled and masked sets `lost_o` and leaves the saved-PC and description registers unchanged. `lost_o` stays set through idle cycles and set-handler strobes, and only a re-arm strobe clears it.
- R8: An alert that arrives while no handler is registered is dropped. It gives no pulse and changes neither the saved-PC register, the description registers nor `lost_o`.
- R9: A re-arm strobe in the same cycle as an alert on a masked unit lets that alert be accepted. `lost_o` stays 0.
- R10: An alert in the same cycle as a clear-handler strobe is dropped.
- R11: Synchronous reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_hdl_i | input | 1 | Register handler strobe |
| hdl_addr_i | input | ADDR_W | Handler address for set_hdl_i |
| clr_hdl_i | input | 1 | Unregister handler strobe |
| rearm_i | input | 1 | Re-enable alert delivery strobe |
| alert_vld_i | input | 1 | Cache alert present |
| alert_line_i | input | LINE_W | Affected line address |
| alert_kind_i | input | 2 | Event kind code |
| kernel_i | input | 1 | Processor privilege, 1 = kernel |
| cur_pc_i | input | ADDR_W | PC of the instruction being interrupted |
| redirect_o | output | 1 | One-cycle fetch redirect request |
| redirect_addr_o | output | ADDR_W | Redirect target (handler address) |
| irq_o | output | 1 | One-cycle interrupt request |
| saved_pc_o | output | ADDR_W | PC saved at last user-mode delivery |
| desc_line_o | output | LINE_W | Line of last accepted alert |
| desc_kind_o | output | 2 | Kind of last accepted alert |
| enabled_o | output | 1 | A handler is registered |
| masked_o | output | 1 | Delivery masked |
| lost_o | output | 1 | Sticky alert-lost status |
| release_all_o | output | 1 | One-cycle request to release all marked lines |

## Verification
Two pairs of functions can land on the same edge.

The first pair is re-arm and a new alert. The bench drives an alert into a masked unit together with the re-arm strobe. It expects a delivery with fresh saved-PC and description values and a clear lost flag; a design that judged the alert against the old mask would show a lost flag and no pulse.

The second pair is clear-handler and an alert. The bench drives them on one edge and expects no pulse, unchanged records and a cleared mask.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    EV_REMOTE_WR = 2'd0,
    EV_LOCAL_WR  = 2'd1,
    EV_EVICT     = 2'd2,
    EV_RSVD      = 2'd3
  } alert_kind_e;
endpackage

// File: rtl/alert_handler_regs.sv
module alert_handler_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_hdl_i,
  input  logic [ADDR_W-1:0] hdl_addr_i,
  input  logic              clr_hdl_i,
  output logic              enabled_o,
  output logic [ADDR_W-1:0] hdl_addr_o,
  output logic              release_o
);
  logic              enabled_q;
  logic [ADDR_W-1:0] addr_q;
  logic              release_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled_q <= 1'b0;
      addr_q    <= '0;
      release_q <= 1'b0;
    end else begin
      release_q <= clr_hdl_i;
      if (clr_hdl_i) begin
        enabled_q <= 1'b0;
      end else if (set_hdl_i) begin
        enabled_q <= 1'b1;
        addr_q    <= hdl_addr_i;
      end
    end
  end

  assign enabled_o  = enabled_q;
  assign hdl_addr_o = addr_q;
  assign release_o  = release_q;

  // R2: unregistering always leaves delivery off
  a_r2_clear_disables: assert property (@(posedge clk) disable iff (rst)
    clr_hdl_i |=> !enabled_q);
  // R1: a lone set leaves delivery on
  a_r1_set_enables: assert property (@(posedge clk) disable iff (rst)
    (set_hdl_i && !clr_hdl_i) |=> enabled_q);
endmodule

// File: rtl/alert_gate.sv
module alert_gate (
  input  logic clk,
  input  logic rst,
  input  logic alert_vld_i,
  input  logic enabled_i,
  input  logic clr_hdl_i,
  input  logic rearm_i,
  output logic accept_o,
  output logic masked_o,
  output logic lost_o
);
  logic masked_q, lost_q;
  logic live, accept, drop_lost;

  assign live      = alert_vld_i && enabled_i && !clr_hdl_i;
  assign accept    = live && (!masked_q || rearm_i);
  assign drop_lost = live && masked_q && !rearm_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      masked_q <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      if (clr_hdl_i)     masked_q <= 1'b0;
      else if (accept)   masked_q <= 1'b1;
      else if (rearm_i)  masked_q <= 1'b0;

      if (rearm_i)        lost_q <= 1'b0;
      else if (drop_lost) lost_q <= 1'b1;
    end
  end

  assign accept_o = accept;
  assign masked_o = masked_q;
  assign lost_o   = lost_q;

  // R6: delivery self-masks
  a_r6_mask_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> masked_q);
  // R7: lost flag only falls on re-arm
  a_r7_lost_sticky: assert property (@(posedge clk) disable iff (rst)
    (lost_q && !rearm_i) |=> lost_q);
  // R9: re-arm paired with an alert never records a loss
  a_r9_rearm_no_loss: assert property (@(posedge clk) disable iff (rst)
    (rearm_i && !lost_q) |=> !lost_q);
endmodule

// File: rtl/alert_capture.sv
module alert_capture #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 26
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accept_i,
  input  logic                     kernel_i,
  input  logic [ADDR_W-1:0]        cur_pc_i,
  input  logic [ADDR_W-1:0]        hdl_addr_i,
  input  logic [LINE_W-1:0]        line_i,
  input  alert_pkg::alert_kind_e   kind_i,
  output logic                     redirect_o,
  output logic [ADDR_W-1:0]        redirect_addr_o,
  output logic                     irq_o,
  output logic [ADDR_W-1:0]        saved_pc_o,
  output logic [LINE_W-1:0]        desc_line_o,
  output alert_pkg::alert_kind_e   desc_kind_o
);
  import alert_pkg::*;

  logic                redirect_q, irq_q;
  logic [ADDR_W-1:0]   target_q, saved_pc_q;
  logic [LINE_W-1:0]   line_q;
  alert_kind_e         kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_q <= 1'b0;
      irq_q      <= 1'b0;
      target_q   <= '0;
      saved_pc_q <= '0;
      line_q     <= '0;
      kind_q     <= EV_REMOTE_WR;
    end else begin
      redirect_q <= accept_i && !kernel_i;
      irq_q      <= accept_i && kernel_i;
      if (accept_i) begin
        line_q <= line_i;
        kind_q <= kind_i;
        if (!kernel_i) begin
          saved_pc_q <= cur_pc_i;
          target_q   <= hdl_addr_i;
        end
      end
    end
  end

  assign redirect_o      = redirect_q;
  assign irq_o           = irq_q;
  assign redirect_addr_o = target_q;
  assign saved_pc_o      = saved_pc_q;
  assign desc_line_o     = line_q;
  assign desc_kind_o     = kind_q;

  // R4: one delivery path per alert
  a_r4_one_path: assert property (@(posedge clk) disable iff (rst)
    !(redirect_q && irq_q));
  // R4: kernel delivery leaves the saved PC alone
  a_r4_kernel_keeps_pc: assert property (@(posedge clk) disable iff (rst)
    (accept_i && kernel_i) |=> $stable(saved_pc_q));
  // R7/R8: no acceptance means the description holds
  a_r7_desc_hold: assert property (@(posedge clk) disable iff (rst)
    !accept_i |=> ($stable(line_q) && $stable(saved_pc_q)));
endmodule

// File: rtl/alert_dispatch_unit.sv
module alert_dispatch_unit #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_hdl_i,
  input  logic [ADDR_W-1:0] hdl_addr_i,
  input  logic              clr_hdl_i,
  input  logic              rearm_i,
  input  logic              alert_vld_i,
  input  logic [LINE_W-1:0] alert_line_i,
  input  logic [1:0]        alert_kind_i,
  input  logic              kernel_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] saved_pc_o,
  output logic [LINE_W-1:0] desc_line_o,
  output logic [1:0]        desc_kind_o,
  output logic              enabled_o,
  output logic              masked_o,
  output logic              lost_o,
  output logic              release_all_o
);
  import alert_pkg::*;

  logic              enabled, accept;
  logic [ADDR_W-1:0] hdl_addr;
  alert_kind_e       kind_in, kind_out;

  assign kind_in = alert_kind_e'(alert_kind_i);

  alert_handler_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .set_hdl_i(set_hdl_i), .hdl_addr_i(hdl_addr_i), .clr_hdl_i(clr_hdl_i),
    .enabled_o(enabled), .hdl_addr_o(hdl_addr), .release_o(release_all_o)
  );

  alert_gate u_gate (
    .clk(clk), .rst(rst),
    .alert_vld_i(alert_vld_i), .enabled_i(enabled), .clr_hdl_i(clr_hdl_i),
    .rearm_i(rearm_i), .accept_o(accept), .masked_o(masked_o), .lost_o(lost_o)
  );

  alert_capture #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_cap (
    .clk(clk), .rst(rst),
    .accept_i(accept), .kernel_i(kernel_i), .cur_pc_i(cur_pc_i),
    .hdl_addr_i(hdl_addr), .line_i(alert_line_i), .kind_i(kind_in),
    .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o), .irq_o(irq_o),
    .saved_pc_o(saved_pc_o), .desc_line_o(desc_line_o), .desc_kind_o(kind_out)
  );

  assign desc_kind_o = kind_out;
  assign enabled_o   = enabled;

  // R8: nothing is delivered while no handler is registered
  a_r8_no_delivery_disabled: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> !(redirect_o || irq_o));
  // R10: clear in the same cycle as an alert suppresses delivery
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr_hdl_i |=> !(redirect_o || irq_o));
endmodule

// File: tb/test_alert_dispatch_unit.sv
`timescale 1ns/1ps
module test_alert_dispatch_unit;
  localparam int AW = 32;
  localparam int LW = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_hdl = 0, clr_hdl = 0, rearm = 0, alert = 0, kern = 0;
  logic [AW-1:0] hdl_addr = '0, pc = '0;
  logic [LW-1:0] line = '0;
  logic [1:0]    kind = '0;
  logic redirect, irq, enabled, masked, lost, release_all;
  logic [AW-1:0] redirect_addr, saved_pc;
  logic [LW-1:0] desc_line;
  logic [1:0]    desc_kind;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  alert_dispatch_unit #(.ADDR_W(AW), .LINE_W(LW)) i_alert_dispatch_unit (
    .clk(clk), .rst(rst), .set_hdl_i(set_hdl), .hdl_addr_i(hdl_addr),
    .clr_hdl_i(clr_hdl), .rearm_i(rearm), .alert_vld_i(alert),
    .alert_line_i(line), .alert_kind_i(kind), .kernel_i(kern), .cur_pc_i(pc),
    .redirect_o(redirect), .redirect_addr_o(redirect_addr), .irq_o(irq),
    .saved_pc_o(saved_pc), .desc_line_o(desc_line), .desc_kind_o(desc_kind),
    .enabled_o(enabled), .masked_o(masked), .lost_o(lost),
    .release_all_o(release_all)
  );

  // Vector: {set,clr,rearm,alert,kern}[58:54] data[53:38] line[37:30] kind[29:28]
  //         exp {redir,irq,mask,lost}[27:24] exp_saved_pc[23:8] exp_line[7:0]
  localparam int NV = 11;
  localparam logic [58:0] VEC [NV] = '{
    {5'b10000, 16'h1000, 8'h00, 2'd0, 4'b0000, 16'h0000, 8'h00}, // R1 register
    {5'b00010, 16'h0040, 8'h11, 2'd0, 4'b1010, 16'h0040, 8'h11}, // R3 user alert
    {5'b00010, 16'h0050, 8'h22, 2'd0, 4'b0011, 16'h0040, 8'h11}, // R7 masked alert
    {5'b00100, 16'h0000, 8'h00, 2'd0, 4'b0000, 16'h0040, 8'h11}, // R6 rearm
    {5'b00011, 16'h0060, 8'h33, 2'd2, 4'b0110, 16'h0040, 8'h33}, // R4 kernel alert
    {5'b00110, 16'h0070, 8'h44, 2'd1, 4'b1010, 16'h0070, 8'h44}, // R9 rearm+alert
    {5'b01010, 16'h0080, 8'h55, 2'd0, 4'b0000, 16'h0070, 8'h44}, // R10 clear+alert
    {5'b00010, 16'h0090, 8'h66, 2'd0, 4'b0000, 16'h0070, 8'h44}, // R8 disabled
    {5'b10000, 16'h2000, 8'h00, 2'd0, 4'b0000, 16'h0070, 8'h44}, // R1 re-register
    {5'b00010, 16'h00A0, 8'h77, 2'd2, 4'b1010, 16'h00A0, 8'h77}, // R3 user alert
    {5'b00000, 16'h0000, 8'h00, 2'd0, 4'b0010, 16'h00A0, 8'h77}  // R3 single pulse
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_hdl = 0; clr_hdl = 0; rearm = 0; alert = 0; kern = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " redirect"}, 32'(redirect), 0);
    chk({tag, " irq"}, 32'(irq), 0);
    chk({tag, " enabled"}, 32'(enabled), 0);
    chk({tag, " masked"}, 32'(masked), 0);
    chk({tag, " lost"}, 32'(lost), 0);
    chk({tag, " release"}, 32'(release_all), 0);
    chk({tag, " saved_pc"}, saved_pc, 0);
    chk({tag, " desc_line"}, 32'(desc_line), 0);
    chk({tag, " target"}, redirect_addr, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R11 reset");
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      v = VEC[i];
      {set_hdl, clr_hdl, rearm, alert, kern} = v[58:54];
      hdl_addr = 32'(v[53:38]);
      pc       = 32'(v[53:38]);
      line     = LW'(v[37:30]);
      kind     = v[29:28];
      step();
      chk($sformatf("R3 redirect vec%0d", i), 32'(redirect), 32'(v[27]));
      chk($sformatf("R4 irq vec%0d", i), 32'(irq), 32'(v[26]));
      chk($sformatf("R6 masked vec%0d", i), 32'(masked), 32'(v[25]));
      chk($sformatf("R7 lost vec%0d", i), 32'(lost), 32'(v[24]));
      chk($sformatf("R3 saved_pc vec%0d", i), saved_pc, 32'(v[23:8]));
      chk($sformatf("R5 desc_line vec%0d", i), 32'(desc_line), 32'(v[7:0]));
    end

    // R1: target of the last user delivery is the second handler; R5: kind code 2
    chk("R1 redirect_addr", redirect_addr, 32'h2000);
    chk("R5 desc_kind evict", 32'(desc_kind), 2);
    chk("R1 enabled", 32'(enabled), 1);

    // R7: loss survives idle and a new registration, clears only on rearm
    alert = 1; pc = 32'h00B0; line = 'h88; kind = 2'd1;
    step();
    chk("R7 lost set", 32'(lost), 1);
    chk("R7 desc unchanged", 32'(desc_line), 32'h77);
    chk("R7 kind unchanged", 32'(desc_kind), 2);
    set_hdl = 1; hdl_addr = 32'h3000;
    step();
    chk("R7 lost after set", 32'(lost), 1);
    step();
    chk("R7 lost after idle", 32'(lost), 1);
    rearm = 1;
    step();
    chk("R7 lost cleared", 32'(lost), 0);
    chk("R6 mask cleared", 32'(masked), 0);

    // R4: kernel delivery keeps saved PC and target
    alert = 1; kern = 1; pc = 32'h00C0; line = 'h99; kind = 2'd1;
    step();
    chk("R4 irq", 32'(irq), 1);
    chk("R4 no redirect", 32'(redirect), 0);
    chk("R4 saved_pc kept", saved_pc, 32'h00A0);
    chk("R5 kind local", 32'(desc_kind), 1);
    step();
    chk("R4 irq single", 32'(irq), 0);

    // R1: new handler used by next user delivery
    rearm = 1;
    step();
    alert = 1; pc = 32'h00D0; line = 'hAA; kind = 2'd0;
    step();
    chk("R1 new target", redirect_addr, 32'h3000);
    chk("R3 redirect", 32'(redirect), 1);
    chk("R5 kind remote", 32'(desc_kind), 0);

    // R2: clear pulse and disable; set and clear together -> clear wins
    set_hdl = 1; clr_hdl = 1; hdl_addr = 32'h4000;
    step();
    chk("R2 release pulse", 32'(release_all), 1);
    chk("R2 disabled", 32'(enabled), 0);
    chk("R2 mask cleared", 32'(masked), 0);
    step();
    chk("R2 release single", 32'(release_all), 0);

    // R11: reset mid-run
    rst = 1;
    step();
    check_reset_state("R11 rerun");
    rst = 0;
    step();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule